// File: doc/BRIEF.md
# Conversion Time Stamp Generator

This block sits beside an analog converter and labels its results with time. It keeps a 16-bit time base. The time base advances at a rate chosen by a prescaler code and wraps from its top value back to zero. A command descriptor is accepted with a valid/ready handshake. The descriptor carries a destination tag and a flag that asks for a time stamp.

When the end-of-sampling strobe arrives, the block copies the time base into its own register, and the counter itself keeps running. When the conversion-done strobe arrives, the block latches the result. It then sends one or two tagged messages over a valid/ready output. The result message always goes first. If a stamp was requested, the captured time base follows it, and both messages carry the same tag.

A configuration port does two things. It programs the prescaler code, and it loads the time base directly; writing zero clears the time base.

Top module: `conv_stamp`

## Requirements
- R1: After reset, msgValid is low, cmdReady is high, the prescaler code is 0 and the time base holds 0.
- R2: While the prescaler code is 0 the time base does not change, and a requested stamp still reports that frozen value.
- R3: A nonzero prescaler code N makes the time base increment once every 2^(N-1) clocks. The first increment comes 2^(N-1) clocks after the edge that wrote the code.
- R4: The time base is 16 bits wide and wraps from 0xFFFF to 0x0000.
- R5: A configuration write with cfgSel=1 loads cfgData into the time base, so writing 0 clears it. A write with cfgSel=0 loads the prescaler code from cfgData[3:0].
- R6: The stamp equals the time base value present in the clock cycle in which sampleEnd is high, while the command is being converted.
- R7: With the stamp request clear, exactly one message is sent. It has msgKind=0 and carries the conversion result on msgData.
- R8: With the stamp request set, two messages are sent. The first has msgKind=0 and carries the result; the second has msgKind=1 and carries the captured stamp.
- R9: Every message of a command carries the tag given with that command.
- R10: While msgValid is high and msgReady is low, msgValid, msgKind, msgTag and msgData hold steady. The stamp message appears only after the result message has been accepted.
- R11: cmdReady is low from the edge that accepts a command until the last message of that command has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command descriptor offered |
| cmdReady | output | 1 | Block can take a command |
| cmdStampReq | input | 1 | Command asks for a time stamp |
| cmdTag | input | 4 | Destination tag of the command |
| sampleEnd | input | 1 | End of input sampling strobe |
| convDone | input | 1 | Conversion finished strobe |
| convResult | input | 16 | Conversion result value |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 selects prescaler code, 1 selects time base |
| cfgData | input | 16 | Configuration write data |
| msgValid | output | 1 | Message offered |
| msgReady | input | 1 | Receiver accepts message |
| msgKind | output | 1 | 0 result, 1 time stamp |
| msgTag | output | 4 | Destination tag |
| msgData | output | 16 | Result or stamp value |

## Verification
Commands are run both without and with a stamp request. This separates the one-message case from the two-message ordering, and the output is held stalled for several cycles so that holding can be told apart from early advancement. Stamps are taken with the prescaler off, at codes 1, 3 and 5, and from a base just below the wrap point. Each expected stamp is computed from the number of clocks between the code write and the sampling strobe. The checks therefore tell a stopped counter, a wrong divide ratio, a wrong capture cycle and a missing wrap apart from one another. Direct loads of the time base, including a clear to zero, are observed through the stamps that follow.

// File: rtl/conv_stamp_pkg.sv
package conv_stamp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CONV    = 2'd1,
    ST_SENDRES = 2'd2,
    ST_SENDTS  = 2'd3
  } stampState_t;

  typedef struct packed {
    logic takeCmd;
    logic grabStamp;
    logic grabResult;
    logic sendStamp;
  } dpCtrl_t;

endpackage

// File: rtl/conv_stamp_timebase.sv
module conv_stamp_timebase #(
  parameter int TB_W = 16,
  parameter int PS_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            psWr,
  input  logic [PS_W-1:0] psData,
  input  logic            cntWr,
  input  logic [TB_W-1:0] cntData,
  output logic [PS_W-1:0] psCode,
  output logic [TB_W-1:0] timeBase
);

  localparam int DIV_RAW = (1 << PS_W) - 2;
  localparam int DIV_W   = (DIV_RAW < 1) ? 1 : DIV_RAW;

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLimit;
  logic [PS_W-1:0]  shiftAmt;
  logic             tick;

  always_comb begin
    shiftAmt = psCode - PS_W'(1);
    divLimit = (DIV_W'(1) << shiftAmt) - DIV_W'(1);
    tick     = (psCode != '0) && (divCnt == divLimit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCode <= '0;
      divCnt <= '0;
    end else if (psWr) begin
      psCode <= psData;
      divCnt <= '0;
    end else if (psCode == '0 || tick) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        timeBase <= '0;
    else if (cntWr)   timeBase <= cntData;
    else if (tick)    timeBase <= timeBase + TB_W'(1);
  end

endmodule

// File: rtl/conv_stamp_ctrl.sv
module conv_stamp_ctrl
  import conv_stamp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  input  logic    cmdStampReq,
  input  logic    sampleEnd,
  input  logic    convDone,
  input  logic    msgReady,
  output logic    cmdReady,
  output logic    msgValid,
  output dpCtrl_t dpCtrl
);

  stampState_t state, nextState;
  logic        wantStamp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      wantStamp <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && cmdValid) wantStamp <= cmdStampReq;
    end
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:    if (cmdValid) nextState = ST_CONV;
      ST_CONV:    if (convDone) nextState = ST_SENDRES;
      ST_SENDRES: if (msgReady) nextState = wantStamp ? ST_SENDTS : ST_IDLE;
      ST_SENDTS:  if (msgReady) nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    cmdReady          = (state == ST_IDLE);
    msgValid          = (state == ST_SENDRES) || (state == ST_SENDTS);
    dpCtrl.takeCmd    = (state == ST_IDLE) && cmdValid;
    dpCtrl.grabStamp  = (state == ST_CONV) && sampleEnd;
    dpCtrl.grabResult = (state == ST_CONV) && convDone;
    dpCtrl.sendStamp  = (state == ST_SENDTS);
  end

endmodule

// File: rtl/conv_stamp_dp.sv
module conv_stamp_dp
  import conv_stamp_pkg::*;
#(
  parameter int TB_W  = 16,
  parameter int RES_W = 16,
  parameter int TAG_W = 4,
  parameter int MSG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          dpCtrl,
  input  logic [TAG_W-1:0] cmdTag,
  input  logic [RES_W-1:0] convResult,
  input  logic [TB_W-1:0]  timeBase,
  output logic             msgKind,
  output logic [TAG_W-1:0] msgTag,
  output logic [MSG_W-1:0] msgData
);

  logic [TAG_W-1:0] tagQ;
  logic [RES_W-1:0] resultQ;
  logic [TB_W-1:0]  stampQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagQ    <= '0;
      resultQ <= '0;
      stampQ  <= '0;
    end else begin
      if (dpCtrl.takeCmd)    tagQ    <= cmdTag;
      if (dpCtrl.grabResult) resultQ <= convResult;
      if (dpCtrl.grabStamp)  stampQ  <= timeBase;
    end
  end

  always_comb begin
    msgKind = dpCtrl.sendStamp;
    msgTag  = tagQ;
    msgData = dpCtrl.sendStamp ? MSG_W'(stampQ) : MSG_W'(resultQ);
  end

endmodule

// File: rtl/conv_stamp.sv
module conv_stamp
  import conv_stamp_pkg::*;
#(
  parameter int TB_W  = 16,
  parameter int RES_W = 16,
  parameter int TAG_W = 4,
  parameter int PS_W  = 4,
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic             cmdStampReq,
  input  logic [TAG_W-1:0] cmdTag,
  input  logic             sampleEnd,
  input  logic             convDone,
  input  logic [RES_W-1:0] convResult,
  input  logic             cfgWrEn,
  input  logic             cfgSel,
  input  logic [CFG_W-1:0] cfgData,
  output logic             msgValid,
  input  logic             msgReady,
  output logic             msgKind,
  output logic [TAG_W-1:0] msgTag,
  output logic [((RES_W > TB_W) ? RES_W : TB_W)-1:0] msgData
);

  localparam int MSG_W = (RES_W > TB_W) ? RES_W : TB_W;

  dpCtrl_t          dpCtrl;
  logic [PS_W-1:0]  psCode;
  logic [TB_W-1:0]  timeBase;

  conv_stamp_timebase #(.TB_W(TB_W), .PS_W(PS_W)) timebase (
    .clk(clk), .rstN(rstN),
    .psWr(cfgWrEn && !cfgSel), .psData(cfgData[PS_W-1:0]),
    .cntWr(cfgWrEn && cfgSel), .cntData(cfgData[TB_W-1:0]),
    .psCode(psCode), .timeBase(timeBase)
  );

  conv_stamp_ctrl ctrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdStampReq(cmdStampReq),
    .sampleEnd(sampleEnd), .convDone(convDone), .msgReady(msgReady),
    .cmdReady(cmdReady), .msgValid(msgValid), .dpCtrl(dpCtrl)
  );

  conv_stamp_dp #(.TB_W(TB_W), .RES_W(RES_W), .TAG_W(TAG_W), .MSG_W(MSG_W)) dp (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl),
    .cmdTag(cmdTag), .convResult(convResult), .timeBase(timeBase),
    .msgKind(msgKind), .msgTag(msgTag), .msgData(msgData)
  );

endmodule

// File: rtl/conv_stamp_chk.sv
module conv_stamp_chk #(
  parameter int TB_W  = 16,
  parameter int TAG_W = 4,
  parameter int PS_W  = 4,
  parameter int MSG_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdReady,
  input logic             cfgWrEn,
  input logic             msgValid,
  input logic             msgReady,
  input logic             msgKind,
  input logic [TAG_W-1:0] msgTag,
  input logic [MSG_W-1:0] msgData,
  input logic [PS_W-1:0]  psCode,
  input logic [TB_W-1:0]  timeBase
);

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgKind) && $stable(msgTag) && $stable(msgData))); // R10

  AST_BUSY_NO_CMD: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> !cmdReady); // R11

  AST_STAMP_AFTER_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(msgValid && msgKind) |-> $past(msgValid && !msgKind && msgReady)); // R8

  AST_SAME_TAG: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgKind) |-> (msgTag == $past(msgTag))); // R9

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (psCode == '0 && !cfgWrEn) |=> (timeBase == $past(timeBase))); // R2

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (timeBase == '1 && !cfgWrEn) |=> (timeBase == '1 || timeBase == '0)); // R4

endmodule

bind conv_stamp conv_stamp_chk #(.TB_W(TB_W), .TAG_W(TAG_W), .PS_W(PS_W), .MSG_W(MSG_W)) chk (
  .clk(clk), .rstN(rstN), .cmdReady(cmdReady), .cfgWrEn(cfgWrEn),
  .msgValid(msgValid), .msgReady(msgReady), .msgKind(msgKind),
  .msgTag(msgTag), .msgData(msgData), .psCode(psCode), .timeBase(timeBase)
);

// File: tb/conv_stamp_test.sv
module conv_stamp_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0, cmdStampReq = 1'b0;
  logic [3:0]  cmdTag = '0;
  logic        sampleEnd = 1'b0, convDone = 1'b0;
  logic [15:0] convResult = '0;
  logic        cfgWrEn = 1'b0, cfgSel = 1'b0;
  logic [15:0] cfgData = '0;
  logic        msgReady = 1'b0;
  logic        cmdReady, msgValid, msgKind;
  logic [3:0]  msgTag;
  logic [15:0] msgData;

  int vecCnt = 0;
  int errCnt = 0;
  int cyc = 0;
  int baseCyc = 0;
  logic [15:0] baseVal = '0;
  int basePeriod = 1;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  conv_stamp uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdStampReq(cmdStampReq), .cmdTag(cmdTag), .sampleEnd(sampleEnd),
    .convDone(convDone), .convResult(convResult), .cfgWrEn(cfgWrEn),
    .cfgSel(cfgSel), .cfgData(cfgData), .msgValid(msgValid),
    .msgReady(msgReady), .msgKind(msgKind), .msgTag(msgTag), .msgData(msgData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic sel, input logic [15:0] val);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgData = val;
    @(posedge clk); #1;
    if (!sel) begin
      baseCyc = cyc;
      basePeriod = (val[3:0] == 0) ? 0 : (1 << (val[3:0] - 1));
    end
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // stop counter, load base, then program the rate
  task automatic setBase(input logic [15:0] b, input int code);
    cfgWrite(1'b0, 16'h0);
    cfgWrite(1'b1, b);
    baseVal = b;
    cfgWrite(1'b0, 16'(code));
  endtask

  function automatic logic [15:0] expStamp(input int sCyc);
    int k;
    k = sCyc - baseCyc;
    if (basePeriod == 0) return baseVal;
    return 16'(int'(baseVal) + (k - 1) / basePeriod);
  endfunction

  task automatic doConv(input logic req, input logic [3:0] tag, input logic [15:0] res,
                        input int sDelay, input int stall, output logic [15:0] stamp,
                        output int sCyc);
    stamp = '0;
    @(negedge clk);
    check("R11 ready when idle", {31'b0, cmdReady}, 32'd1);
    cmdValid = 1'b1; cmdStampReq = req; cmdTag = tag;
    @(negedge clk);
    cmdValid = 1'b0; cmdTag = ~tag;
    check("R11 busy after accept", {31'b0, cmdReady}, 32'd0);
    repeat (sDelay) @(negedge clk);
    sampleEnd = 1'b1;
    @(posedge clk); #1; sCyc = cyc;
    @(negedge clk);
    sampleEnd = 1'b0;
    repeat (2) @(negedge clk);
    convDone = 1'b1; convResult = res;
    @(negedge clk);
    convDone = 1'b0; convResult = ~res;
    for (int i = 0; i < stall; i++) begin
      check("R10 result held while stalled", {30'b0, msgValid, msgKind}, 32'd2);
      @(negedge clk);
    end
    msgReady = 1'b1;
    check("R7 result message valid/kind", {30'b0, msgValid, msgKind}, 32'd2);
    check("R7 result data", {16'b0, msgData}, {16'b0, res});
    check("R9 result tag", {28'b0, msgTag}, {28'b0, tag});
    @(negedge clk);
    if (req) begin
      check("R8 stamp follows result", {30'b0, msgValid, msgKind}, 32'd3);
      check("R9 stamp tag", {28'b0, msgTag}, {28'b0, tag});
      check("R11 busy during stamp", {31'b0, cmdReady}, 32'd0);
      stamp = msgData;
      @(negedge clk);
    end
    check(req ? "R8 nothing after stamp" : "R7 exactly one message", {31'b0, msgValid}, 32'd0);
    check("R11 ready after last message", {31'b0, cmdReady}, 32'd1);
    msgReady = 1'b0;
  endtask

  task automatic tReset();
    logic [15:0] st; int sc;
    check("R1 msgValid low after reset", {31'b0, msgValid}, 32'd0);
    check("R1 cmdReady high after reset", {31'b0, cmdReady}, 32'd1);
    repeat (5) @(negedge clk);
    doConv(1'b1, 4'h3, 16'h0101, 3, 0, st, sc);
    check("R1 time base zero and stopped after reset", {16'b0, st}, 32'h0);
  endtask

  task automatic tSingle();
    logic [15:0] st; int sc;
    doConv(1'b0, 4'h5, 16'hA5A5, 1, 0, st, sc);
    doConv(1'b0, 4'hC, 16'h1E3C, 2, 3, st, sc);
  endtask

  task automatic tFrozen();
    logic [15:0] st; int sc;
    setBase(16'h1234, 0);
    doConv(1'b1, 4'h9, 16'h7777, 2, 3, st, sc);
    check("R5 loaded value reported, R2 frozen", {16'b0, st}, 32'h1234);
    repeat (20) @(negedge clk);
    doConv(1'b1, 4'hA, 16'h8888, 4, 0, st, sc);
    check("R2 still frozen later", {16'b0, st}, 32'h1234);
    cfgWrite(1'b1, 16'h0000);
    doConv(1'b1, 4'h1, 16'h4444, 1, 0, st, sc);
    check("R5 write of zero clears time base", {16'b0, st}, 32'h0);
  endtask

  task automatic tRates();
    logic [15:0] st; int sc;
    setBase(16'h0000, 1);
    doConv(1'b1, 4'h2, 16'h0F0F, 3, 0, st, sc);
    check("R3 R6 code 1 every clock", {16'b0, st}, {16'b0, expStamp(sc)});
    setBase(16'h0100, 3);
    doConv(1'b1, 4'h6, 16'h3030, 5, 2, st, sc);
    check("R3 R6 code 3 every 4 clocks", {16'b0, st}, {16'b0, expStamp(sc)});
    doConv(1'b1, 4'h6, 16'h3131, 9, 0, st, sc);
    check("R3 code 3 second capture", {16'b0, st}, {16'b0, expStamp(sc)});
    setBase(16'h0040, 5);
    doConv(1'b1, 4'h7, 16'h5050, 40, 1, st, sc);
    check("R3 R6 code 5 every 16 clocks", {16'b0, st}, {16'b0, expStamp(sc)});
  endtask

  task automatic tWrap();
    logic [15:0] st; int sc;
    setBase(16'hFFFE, 1);
    doConv(1'b1, 4'hF, 16'hFFFF, 4, 0, st, sc);
    check("R4 wrap past 0xFFFF", {16'b0, st}, {16'b0, expStamp(sc)});
    check("R4 wrapped value small", {31'b0, (st < 16'h0010)}, 32'd1);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tSingle();
    tFrozen();
    tRates();
    tWrap();
    repeat (3) @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    vecCnt++;
    errCnt++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

endmodule